// File: doc/BRIEF.md
# Ping-Pong Receive Buffer for a Host-to-Device Endpoint

This block holds received packets for a single host-to-device endpoint in one or two byte banks. A host-side packet engine delivers each packet as a start strobe, a run of byte strobes and an end strobe. If a bank is free when the start strobe arrives, the bytes are written into it and the packet is acknowledged. If no bank is free, the bytes are dropped and the packet is refused. The accept or refuse answer appears one cycle after the end strobe.

The CPU side sees one bank at a time. When that bank holds a packet, a busy bit and a receive flag are raised. The receive flag, gated by an enable input, drives the endpoint interrupt. A byte counter shows how many bytes are still unread. The CPU pulls bytes through a data port. It clears the flag and releases the bank through separate bits of a control write. Releasing a bank moves the CPU side to the other bank. If the host has already filled that bank, the flag and busy bit come back on the following cycle. In two-bank mode the host fills one bank while the CPU drains the other.

Top module: `oep_bank_ctrl`

## Requirements
- R1: One cycle after a packet is committed to the bank the CPU side points at, and while that bank is not yet busy, busy_o and rx_done_o both become 1 and byte_cnt_o shows the packet length. rx_done_o is never 1 while busy_o is 0.
- R2: ep_irq_o is 1 exactly when rx_done_o is 1 and rx_ie_i is 1.
- R3: A control write (ctl_wr_i = 1) with ctl_wdata_i bit 0 = 1 clears rx_done_o on the next cycle and leaves busy_o unchanged. A control write with bit 0 = 0 leaves rx_done_o unchanged.
- R4: While busy_o is 1, byte_cnt_o equals the number of unread bytes in the current bank, and rd_allowed_o is 1 exactly when that number is nonzero. While busy_o is 0, byte_cnt_o is 0.
- R5: A read strobe (rd_req_i = 1) while rd_allowed_o is 1 places the next unread byte, in arrival order, on rd_data_o one cycle later and lowers byte_cnt_o by one. After the last byte, rd_allowed_o is 0.
- R6: A control write with ctl_wdata_i bit 1 = 1 while busy_o is 1 frees the current bank. On the next cycle busy_o, rx_done_o and byte_cnt_o are 0, and the CPU side moves to the other bank in two-bank mode or stays on bank 0 in one-bank mode.
- R7: hs_vld_o pulses for one cycle, one cycle after pkt_end_i. hs_ack_o is 1 (ACK) if a bank was free at pkt_start_i and 0 (NAK) if it was not. A refused packet changes no bank.
- R8: With dual_bank_i = 1, the host fills the other bank while the CPU holds one. When the CPU releases a bank and the other bank is already full, busy_o and rx_done_o return to 1 one cycle after the release.
- R9: A read strobe while rd_allowed_o is 0 gives rd_data_o = 0 on the next cycle and leaves byte_cnt_o unchanged.
- R10: A packet longer than BANK_BYTES keeps only its first BANK_BYTES bytes. While that bank is current, cur_ovf_o is 1. It returns to 0 after the bank is released.
- R11: With dual_bank_i = 0, only bank 0 is used. A second packet is refused with NAK until the CPU releases the bank, and is accepted after the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dual_bank_i | input | 1 | 1 = two banks, 0 = one bank; change only while both banks are empty |
| rx_ie_i | input | 1 | Receive interrupt enable |
| pkt_start_i | input | 1 | Packet start strobe |
| pkt_byte_vld_i | input | 1 | Packet byte strobe |
| pkt_byte_i | input | DATA_W | Packet byte |
| pkt_end_i | input | 1 | Packet end strobe |
| hs_vld_o | output | 1 | Handshake answer valid |
| hs_ack_o | output | 1 | 1 = ACK, 0 = NAK |
| ctl_wr_i | input | 1 | Control write strobe |
| ctl_wdata_i | input | 2 | Bit 0 clears the receive flag, bit 1 releases the bank |
| rd_req_i | input | 1 | Data port read strobe |
| rd_data_o | output | DATA_W | Read data, valid one cycle after the strobe |
| rx_done_o | output | 1 | Receive flag |
| busy_o | output | 1 | Current bank holds a packet |
| byte_cnt_o | output | $clog2(BANK_BYTES+1) | Unread bytes in the current bank |
| rd_allowed_o | output | 1 | Unread bytes remain |
| cur_ovf_o | output | 1 | Current bank's packet was truncated |
| ep_irq_o | output | 1 | Endpoint interrupt |

## Verification
The assertions assume that each start, byte and end strobe arrives in its own cycle. They also assume that bytes come only between a start and its end, and that dual_bank_i changes only while neither bank holds a packet. The bench drives every packet through one task that spaces these strobes one per cycle. It changes the mode only after both banks have been drained and released. Reads and control writes come from separate tasks, so they never overlap a mode change.

// File: rtl/oep_pkg.sv
package oep_pkg;
   localparam int NUM_BANKS   = 2;
   localparam int CTL_W       = 2;
   localparam int CTL_ACK_BIT = 0;
   localparam int CTL_REL_BIT = 1;

   typedef enum logic [1:0] {
      RXS_IDLE = 2'd0,
      RXS_TAKE = 2'd1,
      RXS_DROP = 2'd2
   } rx_state_e;
endpackage

// File: rtl/oep_bank_mem.sv
module oep_bank_mem
   import oep_pkg::*;
#(
   parameter int BANK_BYTES = 64,
   parameter int DATA_W     = 8,
   localparam int IDX_W     = $clog2(BANK_BYTES)
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic              wr_bank,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_bank,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_word
);
   logic [NUM_BANKS-1:0][DATA_W-1:0] bank_word;

   for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
      logic [DATA_W-1:0] store [BANK_BYTES];
      always_ff @(posedge clk) begin
         if (wr_en && (wr_bank == 1'(g))) begin
            store[wr_idx] <= wr_data;
         end
      end
      assign bank_word[g] = store[rd_idx];
   end

   assign rd_word = bank_word[rd_bank];
endmodule

// File: rtl/oep_host_side.sv
module oep_host_side
   import oep_pkg::*;
#(
   parameter int BANK_BYTES = 64,
   parameter int DATA_W     = 8,
   localparam int IDX_W     = $clog2(BANK_BYTES),
   localparam int CNT_W     = $clog2(BANK_BYTES + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 dual_bank,
   input  logic                 pkt_start,
   input  logic                 pkt_byte_vld,
   input  logic [DATA_W-1:0]    pkt_byte,
   input  logic                 pkt_end,
   input  logic [NUM_BANKS-1:0] bank_full,
   output logic                 wr_en,
   output logic                 wr_bank,
   output logic [IDX_W-1:0]     wr_idx,
   output logic [DATA_W-1:0]    wr_data,
   output logic                 commit,
   output logic                 commit_bank,
   output logic [CNT_W-1:0]     commit_len,
   output logic                 commit_ovf,
   output logic                 hs_vld,
   output logic                 hs_ack
);
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BANK_BYTES);
   localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);

   rx_state_e        state;
   logic             host_ptr;
   logic [CNT_W-1:0] wcnt;
   logic             ovf;
   logic             room;

   assign room        = (wcnt < FULL_CNT);
   assign wr_en       = (state == RXS_TAKE) && pkt_byte_vld && room;
   assign wr_bank     = host_ptr;
   assign wr_idx      = wcnt[IDX_W-1:0];
   assign wr_data     = pkt_byte;
   assign commit      = (state == RXS_TAKE) && pkt_end;
   assign commit_bank = host_ptr;
   assign commit_len  = wcnt;
   assign commit_ovf  = ovf;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= RXS_IDLE;
         host_ptr <= 1'b0;
         wcnt     <= '0;
         ovf      <= 1'b0;
         hs_vld   <= 1'b0;
         hs_ack   <= 1'b0;
      end else begin
         hs_vld <= 1'b0;
         unique case (state)
            RXS_IDLE: begin
               if (pkt_start) begin
                  wcnt <= '0;
                  ovf  <= 1'b0;
                  state <= bank_full[host_ptr] ? RXS_DROP : RXS_TAKE;
               end
            end
            RXS_TAKE: begin
               if (pkt_end) begin
                  state    <= RXS_IDLE;
                  hs_vld   <= 1'b1;
                  hs_ack   <= 1'b1;
                  host_ptr <= dual_bank ? ~host_ptr : 1'b0;
               end else if (pkt_byte_vld) begin
                  if (room) wcnt <= wcnt + ONE_CNT;
                  else      ovf  <= 1'b1;
               end
            end
            RXS_DROP: begin
               if (pkt_end) begin
                  state  <= RXS_IDLE;
                  hs_vld <= 1'b1;
                  hs_ack <= 1'b0;
               end
            end
            default: state <= RXS_IDLE;
         endcase
      end
   end

   AST_NAK_NO_BANK: assert property (@(posedge clk) disable iff (!rst_n)
      (state == RXS_IDLE && pkt_start && bank_full[host_ptr]) |=> (state == RXS_DROP))
      else $error("refused packet entered a bank"); // R7
   AST_HS_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
      hs_vld |-> $past(pkt_end))
      else $error("handshake without end strobe"); // R7
   AST_WCNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      wcnt <= FULL_CNT)
      else $error("write count beyond bank"); // R10
   AST_SINGLE_PTR: assert property (@(posedge clk) disable iff (!rst_n)
      (!dual_bank && hs_vld) |-> !host_ptr)
      else $error("single bank mode left bank 0"); // R11
endmodule

// File: rtl/oep_cpu_side.sv
module oep_cpu_side
   import oep_pkg::*;
#(
   parameter int BANK_BYTES = 64,
   parameter int DATA_W     = 8,
   localparam int IDX_W     = $clog2(BANK_BYTES),
   localparam int CNT_W     = $clog2(BANK_BYTES + 1)
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            dual_bank,
   input  logic [NUM_BANKS-1:0]            bank_full,
   input  logic [NUM_BANKS-1:0][CNT_W-1:0] bank_len,
   input  logic [NUM_BANKS-1:0]            bank_ovf,
   input  logic                            ctl_wr,
   input  logic [CTL_W-1:0]                ctl_wdata,
   input  logic                            rd_req,
   input  logic [DATA_W-1:0]               mem_word,
   output logic                            cpu_ptr,
   output logic [IDX_W-1:0]                rd_idx,
   output logic                            release_now,
   output logic                            busy,
   output logic                            rx_done,
   output logic [CNT_W-1:0]                byte_cnt,
   output logic                            rd_allowed,
   output logic [DATA_W-1:0]               rd_data,
   output logic                            cur_ovf
);
   localparam logic [CNT_W-1:0] ONE_CNT = CNT_W'(1);
   localparam logic [IDX_W-1:0] ONE_IDX = IDX_W'(1);

   logic load_now;
   logic take_byte;

   assign release_now = ctl_wr && ctl_wdata[CTL_REL_BIT] && busy;
   assign load_now    = !busy && bank_full[cpu_ptr];
   assign rd_allowed  = busy && (byte_cnt != '0);
   assign take_byte   = rd_req && rd_allowed && !release_now;
   assign cur_ovf     = busy && bank_ovf[cpu_ptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         rx_done  <= 1'b0;
         cpu_ptr  <= 1'b0;
         byte_cnt <= '0;
         rd_idx   <= '0;
      end else if (release_now) begin
         busy     <= 1'b0;
         rx_done  <= 1'b0;
         byte_cnt <= '0;
         rd_idx   <= '0;
         cpu_ptr  <= dual_bank ? ~cpu_ptr : 1'b0;
      end else if (load_now) begin
         busy     <= 1'b1;
         rx_done  <= 1'b1;
         byte_cnt <= bank_len[cpu_ptr];
         rd_idx   <= '0;
      end else begin
         if (ctl_wr && ctl_wdata[CTL_ACK_BIT]) rx_done <= 1'b0;
         if (take_byte) begin
            byte_cnt <= byte_cnt - ONE_CNT;
            rd_idx   <= rd_idx + ONE_IDX;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         rd_data <= '0;
      else if (take_byte) rd_data <= mem_word;
      else                rd_data <= '0;
   end

   AST_FLAG_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done |-> busy)
      else $error("receive flag without busy bank"); // R1
   AST_ZERO_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && ctl_wdata == '0 && rx_done) |=> rx_done)
      else $error("zero write cleared the flag"); // R3
   AST_READ_DECR: assert property (@(posedge clk) disable iff (!rst_n)
      take_byte |=> (byte_cnt == $past(byte_cnt) - ONE_CNT))
      else $error("read did not lower the count"); // R5
   AST_RELEASE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
      release_now |=> (!busy && !rx_done && byte_cnt == '0))
      else $error("release left bank busy"); // R6
   AST_IDLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !rd_allowed && !load_now) |=> (rd_data == '0 && $stable(byte_cnt)))
      else $error("read while empty changed state"); // R9
endmodule

// File: rtl/oep_bank_ctrl.sv
module oep_bank_ctrl
   import oep_pkg::*;
#(
   parameter int BANK_BYTES = 64,
   parameter int DATA_W     = 8,
   localparam int IDX_W     = $clog2(BANK_BYTES),
   localparam int CNT_W     = $clog2(BANK_BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dual_bank_i,
   input  logic              rx_ie_i,
   input  logic              pkt_start_i,
   input  logic              pkt_byte_vld_i,
   input  logic [DATA_W-1:0] pkt_byte_i,
   input  logic              pkt_end_i,
   output logic              hs_vld_o,
   output logic              hs_ack_o,
   input  logic              ctl_wr_i,
   input  logic [1:0]        ctl_wdata_i,
   input  logic              rd_req_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              rx_done_o,
   output logic              busy_o,
   output logic [CNT_W-1:0]  byte_cnt_o,
   output logic              rd_allowed_o,
   output logic              cur_ovf_o,
   output logic              ep_irq_o
);
   if (BANK_BYTES < 2) begin : g_bad_depth
      $error("BANK_BYTES must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("DATA_W must be at least 1");
   end

   logic                            wr_en, wr_bank;
   logic [IDX_W-1:0]                wr_idx, rd_idx;
   logic [DATA_W-1:0]               wr_data, mem_word;
   logic                            commit, commit_bank, commit_ovf;
   logic [CNT_W-1:0]                commit_len;
   logic                            cpu_ptr, release_now;
   logic [NUM_BANKS-1:0]            bank_full, bank_ovf;
   logic [NUM_BANKS-1:0][CNT_W-1:0] bank_len;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_state
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            bank_full[b] <= 1'b0;
            bank_ovf[b]  <= 1'b0;
            bank_len[b]  <= '0;
         end else if (commit && (commit_bank == 1'(b))) begin
            bank_full[b] <= 1'b1;
            bank_ovf[b]  <= commit_ovf;
            bank_len[b]  <= commit_len;
         end else if (release_now && (cpu_ptr == 1'(b))) begin
            bank_full[b] <= 1'b0;
            bank_ovf[b]  <= 1'b0;
         end
      end
   end

   oep_host_side #(.BANK_BYTES(BANK_BYTES), .DATA_W(DATA_W)) u_host (
      .clk(clk), .rst_n(rst_n), .dual_bank(dual_bank_i),
      .pkt_start(pkt_start_i), .pkt_byte_vld(pkt_byte_vld_i),
      .pkt_byte(pkt_byte_i), .pkt_end(pkt_end_i), .bank_full(bank_full),
      .wr_en(wr_en), .wr_bank(wr_bank), .wr_idx(wr_idx), .wr_data(wr_data),
      .commit(commit), .commit_bank(commit_bank), .commit_len(commit_len),
      .commit_ovf(commit_ovf), .hs_vld(hs_vld_o), .hs_ack(hs_ack_o)
   );

   oep_bank_mem #(.BANK_BYTES(BANK_BYTES), .DATA_W(DATA_W)) u_mem (
      .clk(clk), .wr_en(wr_en), .wr_bank(wr_bank), .wr_idx(wr_idx),
      .wr_data(wr_data), .rd_bank(cpu_ptr), .rd_idx(rd_idx), .rd_word(mem_word)
   );

   oep_cpu_side #(.BANK_BYTES(BANK_BYTES), .DATA_W(DATA_W)) u_cpu (
      .clk(clk), .rst_n(rst_n), .dual_bank(dual_bank_i),
      .bank_full(bank_full), .bank_len(bank_len), .bank_ovf(bank_ovf),
      .ctl_wr(ctl_wr_i), .ctl_wdata(ctl_wdata_i), .rd_req(rd_req_i),
      .mem_word(mem_word), .cpu_ptr(cpu_ptr), .rd_idx(rd_idx),
      .release_now(release_now), .busy(busy_o), .rx_done(rx_done_o),
      .byte_cnt(byte_cnt_o), .rd_allowed(rd_allowed_o), .rd_data(rd_data_o),
      .cur_ovf(cur_ovf_o)
   );

   assign ep_irq_o = rx_done_o & rx_ie_i;

   AST_COMMIT_FREE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> !bank_full[commit_bank])
      else $error("packet committed over a full bank"); // R7
   AST_RELOAD_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (release_now && dual_bank_i && bank_full[~cpu_ptr]) |=> ##1 (busy_o && rx_done_o))
      else $error("full next bank not raised after release"); // R8
endmodule

// File: tb/oep_bank_ctrl_tb.sv
`timescale 1ns/1ps
module oep_bank_ctrl_tb;
   localparam int BB = 64;
   localparam int DW = 8;
   localparam int CW = $clog2(BB + 1);

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic rst_n = 1'b0, dual = 1'b0, rx_ie = 1'b0;
   logic pkt_start = 1'b0, pkt_vld = 1'b0, pkt_end = 1'b0;
   logic [DW-1:0] pkt_byte = '0;
   logic hs_vld, hs_ack, ctl_wr = 1'b0, rd_req = 1'b0;
   logic [1:0] ctl_wdata = 2'b00;
   logic [DW-1:0] rd_data;
   logic rx_done, busy, rd_allowed, cur_ovf, ep_irq;
   logic [CW-1:0] byte_cnt;

   oep_bank_ctrl #(.BANK_BYTES(BB), .DATA_W(DW)) u_dut (
      .clk(clk), .rst_n(rst_n), .dual_bank_i(dual), .rx_ie_i(rx_ie),
      .pkt_start_i(pkt_start), .pkt_byte_vld_i(pkt_vld), .pkt_byte_i(pkt_byte),
      .pkt_end_i(pkt_end), .hs_vld_o(hs_vld), .hs_ack_o(hs_ack),
      .ctl_wr_i(ctl_wr), .ctl_wdata_i(ctl_wdata), .rd_req_i(rd_req),
      .rd_data_o(rd_data), .rx_done_o(rx_done), .busy_o(busy),
      .byte_cnt_o(byte_cnt), .rd_allowed_o(rd_allowed), .cur_ovf_o(cur_ovf),
      .ep_irq_o(ep_irq)
   );

   int total = 0, bad = 0;
   bit finished = 0;
   logic [DW-1:0] byte_q[$];
   int            len_q[$];
   bit            ovf_q[$];

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // driver: sends a packet and pushes what the CPU should later see
   task automatic send_pkt(input int n, input int seed, input bit exp_ack, input string req);
      pkt_start = 1'b1;
      @(negedge clk) pkt_start = 1'b0;
      for (int i = 0; i < n; i++) begin
         pkt_vld = 1'b1; pkt_byte = DW'(seed + 7 * i);
         @(negedge clk);
      end
      pkt_vld = 1'b0; pkt_end = 1'b1;
      @(negedge clk) pkt_end = 1'b0;
      chk(hs_vld == 1'b1, req, int'(hs_vld), 1);
      chk(hs_ack == exp_ack, req, int'(hs_ack), int'(exp_ack));
      if (exp_ack) begin
         for (int i = 0; i < n && i < BB; i++) byte_q.push_back(DW'(seed + 7 * i));
         len_q.push_back(n < BB ? n : BB);
         ovf_q.push_back(n > BB);
      end
   endtask

   task automatic cpu_write(input logic [1:0] v);
      ctl_wr = 1'b1; ctl_wdata = v;
      @(negedge clk) ctl_wr = 1'b0; ctl_wdata = 2'b00;
   endtask

   task automatic rd_one(output logic [DW-1:0] d);
      rd_req = 1'b1;
      @(negedge clk) rd_req = 1'b0;
      d = rd_data;
   endtask

   // monitor: pops the expected packet and compares as bytes come out
   task automatic drain();
      int n;
      bit o;
      logic [DW-1:0] d, e;
      n = len_q.pop_front();
      o = ovf_q.pop_front();
      chk(busy == 1'b1, "R1 busy", int'(busy), 1);
      chk(int'(byte_cnt) == n, "R4 count", int'(byte_cnt), n);
      chk(cur_ovf == o, "R10 overflow", int'(cur_ovf), int'(o));
      chk(rd_allowed == (n != 0), "R4 rd_allowed", int'(rd_allowed), int'(n != 0));
      for (int i = 0; i < n; i++) begin
         rd_one(d);
         e = byte_q.pop_front();
         chk(d == e, "R5 data", int'(d), int'(e));
         chk(int'(byte_cnt) == n - 1 - i, "R5 count", int'(byte_cnt), n - 1 - i);
      end
      chk(rd_allowed == 1'b0, "R5 empty", int'(rd_allowed), 0);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      logic [DW-1:0] d;
      repeat (3) @(negedge clk);
      chk(busy == 0 && rx_done == 0 && ep_irq == 0, "R1 reset flags", int'(busy), 0);
      chk(byte_cnt == 0 && rd_allowed == 0 && hs_vld == 0, "R4 reset count", int'(byte_cnt), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // one-bank mode
      send_pkt(5, 16, 1'b1, "R7 ack");
      @(negedge clk);
      chk(busy == 1'b1, "R1 busy set", int'(busy), 1);
      chk(rx_done == 1'b1, "R1 flag set", int'(rx_done), 1);
      chk(byte_cnt == 5, "R4 length", int'(byte_cnt), 5);
      rx_ie = 1'b1; #1;
      chk(ep_irq == 1'b1, "R2 irq on", int'(ep_irq), 1);
      rx_ie = 1'b0; #1;
      chk(ep_irq == 1'b0, "R2 irq masked", int'(ep_irq), 0);
      rx_ie = 1'b1;
      cpu_write(2'b00);
      chk(rx_done == 1'b1, "R3 zero write", int'(rx_done), 1);
      cpu_write(2'b01);
      chk(rx_done == 1'b0, "R3 clear", int'(rx_done), 0);
      chk(busy == 1'b1, "R3 busy kept", int'(busy), 1);
      chk(ep_irq == 1'b0, "R2 irq off", int'(ep_irq), 0);
      send_pkt(3, 99, 1'b0, "R11 nak single");
      drain();
      rd_one(d);
      chk(d == 0, "R9 empty data", int'(d), 0);
      chk(byte_cnt == 0, "R9 count kept", int'(byte_cnt), 0);
      cpu_write(2'b10);
      chk(busy == 1'b0, "R6 freed", int'(busy), 0);
      @(negedge clk);
      chk(busy == 1'b0, "R6 no next bank", int'(busy), 0);
      send_pkt(2, 40, 1'b1, "R11 ack after release");
      @(negedge clk);
      drain();
      cpu_write(2'b11);
      @(negedge clk);

      // two-bank mode
      dual = 1'b1;
      send_pkt(3, 1, 1'b1, "R7 ack A");
      send_pkt(4, 60, 1'b1, "R8 host fills other bank");
      send_pkt(2, 80, 1'b0, "R7 nak both full");
      drain();
      cpu_write(2'b10);
      chk(busy == 1'b0, "R6 release", int'(busy), 0);
      @(negedge clk);
      chk(busy == 1'b1 && rx_done == 1'b1, "R8 reload", int'(rx_done), 1);
      chk(byte_cnt == 4, "R8 next length", int'(byte_cnt), 4);
      drain();
      cpu_write(2'b10);
      chk(rx_done == 1'b0, "R6 flag cleared", int'(rx_done), 0);
      @(negedge clk);
      send_pkt(70, 3, 1'b1, "R10 long packet");
      @(negedge clk);
      drain();
      cpu_write(2'b10);
      chk(cur_ovf == 1'b0, "R10 overflow cleared", int'(cur_ovf), 0);
      rd_one(d);
      chk(d == 0, "R9 idle read", int'(d), 0);

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule